// File: doc/BRIEF.md
# Auto-Baud Serial Boot Handshake

This block sits on a serial receive/transmit pin pair. It works out the bit rate of a host before any data moves. After reset it stays quiet for a fixed settling time. Then it times the low stretch of each all-zero byte that the host keeps sending. From that time it derives a bit-time divisor in clock cycles and uses it for its own small 8N1 transmitter and receiver.

Two consecutive measurements that agree lock the divisor. The block then sends one acknowledge byte of 0x00 at the new rate and waits for a single reply byte. A reply of 0x55 raises `ready_o`, and the locked divisor then stays on `div_o` for a boot loader to use. A wrong reply, a framing error, an overlong low stretch or a divisor that is too small raises `error_o` instead. Only a reset leaves either final state.

The block has no streaming data port. The serial lines are raw pins, and `ready_o`, `error_o` and `div_o` are plain level outputs with no valid/ready handshake and no back-pressure.

Top module: `abaud_handshake`

## Requirements
- R1: Serial frames on both pins use 8N1 format: one low start bit, eight data bits sent least significant bit first, and one high stop bit. `tx_o` idles high and stays high except while the acknowledge frame is being sent.
- R2: For the first SETTLE_CYC clock cycles after reset is released, activity on `rx_i` is ignored and no measurement is taken.
- R3: Measurement begins only after the synchronised receive line has been seen high and then falls. A low level that is already present when measuring is enabled is not timed.
- R4: The divisor is computed from the latest low-period count N as floor((N + 4) / 9), which is N/9 rounded to nearest, because one zero byte is low for 9 bit times.
- R5: A divisor is accepted only when the latest count differs from the previous count by no more than the previous count shifted right by 4. Otherwise the latest count becomes the new reference and measurement continues.
- R6: After acceptance, exactly one 0x00 frame is transmitted on `tx_o` at the accepted divisor.
- R7: After the acknowledge frame, a received byte of 0x55 with a valid stop bit sets `ready_o`, and `div_o` then holds the accepted divisor.
- R8: After the acknowledge frame, a received byte other than 0x55, or a low stop bit, sets `error_o`.
- R9: A low period that outlasts the all-ones value of the CNT_W-bit counter sets `error_o`.
- R10: An accepted divisor below MIN_DIV sets `error_o` and no acknowledge frame is sent.
- R11: In reset, `tx_o` is 1, `ready_o` and `error_o` are 0, and `div_o` is 0.
- R12: `ready_o` and `error_o` are never both 1, and each stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line from the host, idle high |
| tx_o | output | 1 | Serial line to the host, idle high |
| div_o | output | CNT_W-3 | Locked bit-time divisor in clock cycles, meaningful once `ready_o` is set |
| ready_o | output | 1 | Handshake completed |
| error_o | output | 1 | Handshake failed, held until reset |

## Verification
The hardest states to reach from the pins are the ones where a low level must be ignored. One case is a full-length zero pulse that falls entirely inside the settling window. The other is a line that is already low when measuring starts. The stimulus builds each case with a low pulse whose length equals a later valid frame. A faulty design would then see two matching periods and send its acknowledge early, while a correct one stays silent until a second genuine frame arrives. The tolerance rule is reached with hand-picked pairs of low periods that sit just inside or just outside one sixteenth of the reference.

// File: rtl/abaud_pkg.sv
package abaud_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_MEASURE,
    ST_ACK,
    ST_ACK_WAIT,
    ST_REPLY,
    ST_READY,
    ST_FAIL
  } seq_state_t;

  localparam logic [7:0] ACK_BYTE   = 8'h00;
  localparam logic [7:0] REPLY_BYTE = 8'h55;
  localparam int         ZERO_LOW_BITS = 9;

endpackage

// File: rtl/abaud_sync.sv
module abaud_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b11;
    else         stage_q <= {stage_q[0], d_i};
  end

  assign q_o = stage_q[1];
endmodule

// File: rtl/abaud_lowmeter.sv
module abaud_lowmeter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rx_s_i,
  output logic             done_o,
  output logic [CNT_W-1:0] len_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             seen_idle_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_idle_q <= 1'b0;
      cnt_q       <= '0;
      done_o      <= 1'b0;
      len_o       <= '0;
    end else if (!en_i) begin
      seen_idle_q <= 1'b0;
      cnt_q       <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (rx_s_i) begin
        seen_idle_q <= 1'b1;
        if (cnt_q != '0) begin
          done_o <= 1'b1;
          len_o  <= cnt_q;
        end
        cnt_q <= '0;
      end else if (seen_idle_q && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sat_o = en_i && seen_idle_q && !rx_s_i && (cnt_q == CNT_MAX);

  // counter parks at its ceiling while the line stays low
  p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && en_i) |=> (!en_i || rx_s_i || cnt_q == CNT_MAX));

  // a measurement never completes before an idle level was observed
  p_idle_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !seen_idle_q) |=> !done_o);
endmodule

// File: rtl/abaud_tx.sv
module abaud_tx #(
  parameter int DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tx_o,
  output logic             done_o
);
  logic             busy_q;
  logic [9:0]       shift_q;
  logic [3:0]       bit_q;
  logic [DIV_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      shift_q <= '1;
      bit_q   <= '0;
      cyc_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        shift_q <= {1'b1, data_i, 1'b0};
        busy_q  <= 1'b1;
        bit_q   <= '0;
        cyc_q   <= '0;
      end else if (busy_q) begin
        if (cyc_q == div_i - 1'b1) begin
          cyc_q   <= '0;
          shift_q <= {1'b1, shift_q[9:1]};
          if (bit_q == 4'd9) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end
    end
  end

  assign tx_o = busy_q ? shift_q[0] : 1'b1;

  // every frame opens with a low start bit
  p_start_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !tx_o);
endmodule

// File: rtl/abaud_rx.sv
module abaud_rx #(
  parameter int DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rx_s_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             valid_o,
  output logic             ferr_o,
  output logic [7:0]       data_o
);
  logic             act_q;
  logic [3:0]       bit_q;
  logic [DIV_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      bit_q   <= '0;
      cyc_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else if (!en_i) begin
      act_q   <= 1'b0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      if (!act_q) begin
        if (!rx_s_i) begin
          act_q <= 1'b1;
          bit_q <= '0;
          cyc_q <= (div_i >> 1) - 1'b1;
        end
      end else if (cyc_q != '0) begin
        cyc_q <= cyc_q - 1'b1;
      end else begin
        cyc_q <= div_i - 1'b1;
        if (bit_q == 4'd0) begin
          if (rx_s_i) act_q <= 1'b0;
          else        bit_q <= 4'd1;
        end else if (bit_q != 4'd9) begin
          data_o <= {rx_s_i, data_o[7:1]};
          bit_q  <= bit_q + 1'b1;
        end else begin
          act_q   <= 1'b0;
          valid_o <= rx_s_i;
          ferr_o  <= !rx_s_i;
        end
      end
    end
  end

  p_byte_or_ferr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && ferr_o));
endmodule

// File: rtl/abaud_handshake.sv
module abaud_handshake
  import abaud_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 100,
  parameter int MIN_DIV    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic             tx_o,
  output logic [CNT_W-4:0] div_o,
  output logic             ready_o,
  output logic             error_o
);
  localparam int               DIV_W       = CNT_W - 3;
  localparam int               SET_W       = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SETTLE_LAST = SET_W'(SETTLE_CYC - 1);
  localparam logic [DIV_W-1:0] MIN_D       = DIV_W'(MIN_DIV);
  localparam logic [CNT_W:0]   ROUND_ADD   = (CNT_W+1)'(ZERO_LOW_BITS / 2);
  localparam logic [CNT_W:0]   LOW_BITS    = (CNT_W+1)'(ZERO_LOW_BITS);

  seq_state_t       state_q;
  logic [SET_W-1:0] settle_q;
  logic [CNT_W-1:0] prev_q, len, diff;
  logic             have_prev_q, agree;
  logic [DIV_W-1:0] div_q, div_calc;
  logic [CNT_W:0]   rnd_sum;
  logic             rx_s;
  logic             m_en, m_done, m_sat;
  logic             tx_start, tx_done;
  logic             rx_en, rx_valid, rx_ferr;
  logic [7:0]       rx_data;

  abaud_sync u_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s));

  abaud_lowmeter #(.CNT_W(CNT_W)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(m_en), .rx_s_i(rx_s),
    .done_o(m_done), .len_o(len), .sat_o(m_sat)
  );

  abaud_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_start), .data_i(ACK_BYTE),
    .div_i(div_q), .tx_o(tx_o), .done_o(tx_done)
  );

  abaud_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en), .rx_s_i(rx_s),
    .div_i(div_q), .valid_o(rx_valid), .ferr_o(rx_ferr), .data_o(rx_data)
  );

  always_comb begin
    rnd_sum  = {1'b0, len} + ROUND_ADD;
    div_calc = DIV_W'(rnd_sum / LOW_BITS);
    diff     = (len >= prev_q) ? (len - prev_q) : (prev_q - len);
    agree    = have_prev_q && (diff <= (prev_q >> 4));
    m_en     = (state_q == ST_MEASURE);
    tx_start = (state_q == ST_ACK);
    rx_en    = (state_q == ST_REPLY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_SETTLE;
      settle_q    <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      div_q       <= '0;
    end else begin
      unique case (state_q)
        ST_SETTLE: begin
          if (settle_q == SETTLE_LAST) state_q <= ST_MEASURE;
          else                         settle_q <= settle_q + 1'b1;
        end
        ST_MEASURE: begin
          if (m_sat) begin
            state_q <= ST_FAIL;
          end else if (m_done) begin
            if (agree) begin
              if (div_calc < MIN_D) begin
                state_q <= ST_FAIL;
              end else begin
                div_q   <= div_calc;
                state_q <= ST_ACK;
              end
            end else begin
              prev_q      <= len;
              have_prev_q <= 1'b1;
            end
          end
        end
        ST_ACK:      state_q <= ST_ACK_WAIT;
        ST_ACK_WAIT: if (tx_done) state_q <= ST_REPLY;
        ST_REPLY: begin
          if (rx_ferr)       state_q <= ST_FAIL;
          else if (rx_valid) state_q <= (rx_data == REPLY_BYTE) ? ST_READY : ST_FAIL;
        end
        default: ;
      endcase
    end
  end

  assign div_o   = div_q;
  assign ready_o = (state_q == ST_READY);
  assign error_o = (state_q == ST_FAIL);

  p_tx_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE || state_q == ST_MEASURE || state_q == ST_REPLY || ready_o) |-> tx_o);

  p_no_measure_in_settle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE) |-> !m_done);

  p_div_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $stable(div_o));

  p_min_div_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (div_o >= MIN_D));

  p_ready_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_error_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> (error_o && !ready_o));
endmodule

// File: tb/abaud_handshake_bench.sv
`timescale 1ns/1ps
module abaud_handshake_bench;
  localparam int CW     = 10;
  localparam int SETTLE = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic          tx;
  logic [CW-4:0] div;
  logic          ready, error;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  abaud_handshake #(.CNT_W(CW), .SETTLE_CYC(SETTLE), .MIN_DIV(4)) u_abaud_handshake (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_o(tx),
    .div_o(div), .ready_o(ready), .error_o(error)
  );

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx = 1'b1;
    cyc(4);
    check_eq("R11 tx in reset", int'(tx), 1);
    check_eq("R11 ready in reset", int'(ready), 0);
    check_eq("R11 error in reset", int'(error), 0);
    check_eq("R11 div in reset", int'(div), 0);
    rst_n = 1'b1;
  endtask

  task automatic low(int n);
    rx = 1'b0;
    cyc(n);
    rx = 1'b1;
  endtask

  task automatic send_byte(int d, logic [7:0] b, logic stopv);
    rx = 1'b0;
    cyc(d);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      cyc(d);
    end
    rx = stopv;
    cyc(d);
    rx = 1'b1;
  endtask

  // waits for a frame on tx; returns the 10 sampled bits, start bit in bit 0
  task automatic get_ack(int d, int limit, output int got, output int frame);
    logic [9:0] fr;
    got = 0;
    frame = -1;
    for (int i = 0; i < limit && got == 0; i++) begin
      @(negedge clk);
      if (!tx) got = 1;
    end
    if (got == 1) begin
      cyc(d / 2);
      fr[0] = tx;
      for (int k = 1; k < 10; k++) begin
        cyc(d);
        fr[k] = tx;
      end
      frame = int'(fr);
    end
  endtask

  task automatic run_lock(int l1, int l2, int d, logic [7:0] reply, logic stopv, int exp_ok);
    int got, frame;
    do_reset();
    cyc(SETTLE + 20);
    low(l1);
    cyc(d + 5);
    low(l2);
    get_ack(d, 20 * d + 100, got, frame);
    check_eq("R6 ack sent after agreement", got, 1);
    check_eq("R1 R6 ack frame 0x00 8N1", frame, 512);
    cyc(d);
    send_byte(d, reply, stopv);
    cyc(4 * d + 10);
    check_eq(exp_ok ? "R7 ready after 0x55" : "R8 ready stays low", int'(ready), exp_ok);
    check_eq(exp_ok ? "R7 no error" : "R8 error after bad reply", int'(error), exp_ok ? 0 : 1);
    if (exp_ok == 1) check_eq("R4 R7 locked divisor", int'(div), d);
  endtask

  task automatic expect_silent(int window, string req);
    int got, frame;
    get_ack(4, window, got, frame);
    check_eq(req, got, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int got, frame;

    // R4 R6 R7: sweep of bit times with exact zero-byte low periods
    for (int d = 4; d <= 32; d++) run_lock(9 * d, 9 * d, d, 8'h55, 1'b1, 1);

    // R12: after ready, further line activity changes nothing
    low(90);
    cyc(20);
    low(90);
    cyc(400);
    check_eq("R12 ready held", int'(ready), 1);
    check_eq("R12 error stays low", int'(error), 0);
    check_eq("R12 tx silent after ready", int'(tx), 1);

    // R4 R5: rounding and tolerance inside the window
    run_lock(180, 190, 21, 8'h55, 1'b1, 1);
    run_lock(180, 184, 20, 8'h55, 1'b1, 1);
    run_lock(180, 185, 21, 8'h55, 1'b1, 1);

    // R5: disagreement forces another measurement
    do_reset();
    cyc(SETTLE + 20);
    low(180);
    cyc(30);
    low(216);
    get_ack(24, 400, got, frame);
    check_eq("R5 no lock on disagreeing pair", got, 0);
    low(216);
    get_ack(24, 600, got, frame);
    check_eq("R5 lock on newer reference", got, 1);
    check_eq("R5 ack frame", frame, 512);
    cyc(24);
    send_byte(24, 8'h55, 1'b1);
    cyc(200);
    check_eq("R5 ready", int'(ready), 1);
    check_eq("R5 divisor from newer pair", int'(div), 24);

    // R8: wrong reply bytes and a framing error
    run_lock(90, 90, 10, 8'h54, 1'b1, 0);
    run_lock(90, 90, 10, 8'hAA, 1'b1, 0);
    run_lock(90, 90, 10, 8'h55, 1'b0, 0);
    send_byte(10, 8'h55, 1'b1);
    cyc(100);
    check_eq("R12 error held after later 0x55", int'(error), 1);
    check_eq("R12 ready stays low", int'(ready), 0);

    // R10: divisor below the minimum
    for (int d = 2; d <= 3; d++) begin
      do_reset();
      cyc(SETTLE + 20);
      low(9 * d);
      cyc(10);
      low(9 * d);
      expect_silent(300, "R10 no ack for small divisor");
      check_eq("R10 error for small divisor", int'(error), 1);
      check_eq("R10 ready low", int'(ready), 0);
    end

    // R9: counter saturation
    do_reset();
    cyc(SETTLE + 20);
    low(1100);
    cyc(10);
    check_eq("R9 error on saturation", int'(error), 1);
    check_eq("R9 tx idle", int'(tx), 1);

    // R2: a pulse entirely inside the settling time is not measured
    do_reset();
    cyc(10);
    low(36);
    cyc(SETTLE);
    low(36);
    expect_silent(200, "R2 settle pulse ignored");
    low(36);
    get_ack(4, 200, got, frame);
    check_eq("R2 lock after two real frames", got, 1);
    cyc(4);
    send_byte(4, 8'h55, 1'b1);
    cyc(40);
    check_eq("R2 ready", int'(ready), 1);
    check_eq("R2 divisor", int'(div), 4);

    // R3: a low level spanning the end of settling is not timed
    do_reset();
    cyc(60);
    rx = 1'b0;
    cyc(79);
    rx = 1'b1;
    cyc(20);
    low(36);
    expect_silent(200, "R3 low without prior idle ignored");
    low(36);
    get_ack(4, 200, got, frame);
    check_eq("R3 lock after two timed frames", got, 1);
    check_eq("R3 ack frame", frame, 512);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule